// File: doc/BRIEF.md
# Complementary Pulse-Width Generator with Dead Band

This block produces a pair of complementary pulse-width modulated outputs, `p_o` and `n_o`, for a half-bridge gate driver. It counts cycles of the system clock and compares the count against programmed thresholds. It uses no analog delays and no timed waits. A period counter steps from 0 to `period_i - 1` and then wraps. The primary output is high while the count is below the high-time threshold. The secondary output is the opposite of the primary. At a 100 MHz clock, the settings period 2000 and high-time 1700 give 17 us high and 3 us low in a 20 us frame.

A dead band of `dead_i` cycles can be set. It holds both outputs low after each switching event, so one switch is off before the other turns on. The dead band is formed by comparing windows against the running count, so it needs no separate delay timer. The period, high-time and dead-time inputs are captured only when a new period begins. A change made in the middle of a period takes effect at the next period start. `start_o` marks the first cycle of each period.

Top module: `pwm_pair_top`

## Requirements
- R1: While enabled, the count steps 0, 1, …, `period_i`−1 and then returns to 0 (`period_i` must be at least 1). Outputs are registered, so each output cycle reflects one count value in that order. `start_o` is high exactly in the output cycle for count 0.
- R2: With dead time 0 and 0 < H < period, `p_o` is high for counts k < H and low for H ≤ k < period.
- R3: A high time of 0 gives `p_o` low and `n_o` high for the whole period. A high time at or above the period gives `p_o` high and `n_o` low. No dead band is inserted in either case.
- R4: With dead time 0, `n_o` is the inverse of `p_o` in every enabled output cycle.
- R5: With dead time D and 0 < H < period, `p_o` is high only for D ≤ k < H and `n_o` is high only for H+D ≤ k < period. The rising edge of `p_o` therefore comes D cycles after `n_o` falls, and the rising edge of `n_o` comes D cycles after `p_o` falls.
- R6: `p_o` and `n_o` are never high in the same cycle.
- R7: During reset, and in the output cycle after `en_i` is sampled low, `p_o`, `n_o` and `start_o` are all low. The count is cleared, and the next enable starts again at count 0.
- R8: Period, high time and dead time are captured on the first enabled edge and at each wrap. A change made in the middle of a period does not affect that period.
- R9: When the dead time leaves no active window for an output (D ≥ H for `p_o`, H+D ≥ period for `n_o`), that output stays low for the entire period.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| en_i | input | 1 | Run enable; low clears the count and forces the outputs low |
| period_i | input | CNT_W | Period length in clock cycles (at least 1) |
| high_i | input | CNT_W | Number of counts for which the primary output is high |
| dead_i | input | DT_W | Dead band in clock cycles |
| p_o | output | 1 | Primary drive output |
| n_o | output | 1 | Complementary drive output |
| start_o | output | 1 | One-cycle strobe at count 0 |

## Verification
The assertions check four things on every clock cycle:
- the two outputs never overlap;
- both outputs go low after a disable;
- the count stays inside the captured period;
- the captured configuration stays stable within a period, and the outputs are exact complements whenever the dead band is zero.

The exact pulse placement cannot be expressed by these properties, so only the bench scenarios show it. This covers where each window opens and closes for every combination of period, high time and dead time, the saturated high-time cases, and the suppression of a window that the dead band consumes. The bench scenarios also show that a mid-period update is deferred to the next wrap, and that a restart after a disable begins at count 0.

// File: rtl/pwm_pair_pkg.sv
package pwm_pair_pkg;

  parameter int unsigned CNT_W = 16;
  parameter int unsigned DT_W  = 8;

  typedef struct packed {
    logic [CNT_W-1:0] period;
    logic [CNT_W-1:0] high;
    logic [DT_W-1:0]  dead;
  } pwm_cfg_t;

  // Classification of the high-time setting against the period
  typedef enum logic [1:0] {
    DUTY_ZERO = 2'd0,
    DUTY_FULL = 2'd1,
    DUTY_PART = 2'd2
  } duty_kind_e;

endpackage

// File: rtl/pwm_pair_timer.sv
module pwm_pair_timer
  import pwm_pair_pkg::*;
#(
  parameter int unsigned W = CNT_W
) (
  input  logic           clk_i,
  input  logic           rst_ni,
  input  logic           en_i,
  input  pwm_cfg_t       cfg_i,
  output logic           run_o,
  output logic [W-1:0]   cnt_o,
  output pwm_cfg_t       cfg_o
);

  localparam int unsigned WX = W + 1;

  logic         run_q;
  logic [W-1:0] cnt_q;
  pwm_cfg_t     cfg_q;
  logic         wrap;

  assign wrap = run_q && (({1'b0, cnt_q} + WX'(1)) >= {1'b0, cfg_q.period});

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      run_q <= 1'b0;
      cnt_q <= '0;
      cfg_q <= '0;
    end else if (!en_i) begin
      run_q <= 1'b0;
      cnt_q <= '0;
    end else if (!run_q || wrap) begin
      run_q <= 1'b1;
      cnt_q <= '0;
      cfg_q <= cfg_i;  // capture only at period start
    end else begin
      cnt_q <= cnt_q + W'(1);
    end
  end

  assign run_o = run_q;
  assign cnt_o = cnt_q;
  assign cfg_o = cfg_q;

  p_cnt_range_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (run_q && cfg_q.period != '0) |-> (cnt_q < cfg_q.period));

  p_cfg_hold_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (run_q && cnt_q != '0) |-> ($stable(cfg_q.period) && $stable(cfg_q.high) && $stable(cfg_q.dead)));

endmodule

// File: rtl/pwm_pair_window.sv
module pwm_pair_window
  import pwm_pair_pkg::*;
#(
  parameter int unsigned W       = CNT_W,
  parameter int unsigned DW      = DT_W,
  parameter bit          DEAD_EN = 1'b1
) (
  input  logic [W-1:0]  cnt_i,
  input  logic [W-1:0]  period_i,
  input  logic [W-1:0]  high_i,
  input  logic [DW-1:0] dead_i,
  output logic          p_raw_o,
  output logic          n_raw_o
);

  localparam int unsigned WX = W + 1;

  duty_kind_e    kind;
  logic [WX-1:0] cnt_x, per_x, hi_x;

  assign cnt_x = {1'b0, cnt_i};
  assign per_x = {1'b0, period_i};
  assign hi_x  = {1'b0, high_i};

  always_comb begin
    if (high_i == '0)        kind = DUTY_ZERO;
    else if (hi_x >= per_x)  kind = DUTY_FULL;
    else                     kind = DUTY_PART;
  end

  generate
    if (DEAD_EN) begin : g_dead
      logic [WX-1:0] dt_x, n_on_x;
      logic          p_win, n_win;

      assign dt_x   = WX'(dead_i);
      assign n_on_x = hi_x + dt_x;
      // windows shrink by the dead band at each switching point
      assign p_win  = (cnt_x >= dt_x) && (cnt_x < hi_x);
      assign n_win  = (cnt_x >= n_on_x) && (cnt_x < per_x);

      always_comb begin
        unique case (kind)
          DUTY_ZERO: begin p_raw_o = 1'b0;  n_raw_o = 1'b1;  end
          DUTY_FULL: begin p_raw_o = 1'b1;  n_raw_o = 1'b0;  end
          default:   begin p_raw_o = p_win; n_raw_o = n_win; end
        endcase
      end
    end else begin : g_plain
      logic unused_dead;
      assign unused_dead = ^dead_i;

      always_comb begin
        unique case (kind)
          DUTY_ZERO: p_raw_o = 1'b0;
          DUTY_FULL: p_raw_o = 1'b1;
          default:   p_raw_o = (cnt_x < hi_x);
        endcase
        n_raw_o = ~p_raw_o;
      end
    end
  endgenerate

endmodule

// File: rtl/pwm_pair_outreg.sv
module pwm_pair_outreg (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic en_i,
  input  logic run_i,
  input  logic p_raw_i,
  input  logic n_raw_i,
  input  logic start_raw_i,
  output logic p_o,
  output logic n_o,
  output logic start_o
);

  logic live;
  assign live = en_i && run_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      p_o     <= 1'b0;
      n_o     <= 1'b0;
      start_o <= 1'b0;
    end else begin
      p_o     <= live && p_raw_i;
      n_o     <= live && n_raw_i;
      start_o <= live && start_raw_i;
    end
  end

  p_no_overlap_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(p_o && n_o));

  p_idle_low_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en_i |=> (!p_o && !n_o && !start_o));

endmodule

// File: rtl/pwm_pair_top.sv
module pwm_pair_top
  import pwm_pair_pkg::*;
#(
  parameter int unsigned W       = CNT_W,
  parameter int unsigned DW      = DT_W,
  parameter bit          DEAD_EN = 1'b1
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          en_i,
  input  logic [W-1:0]  period_i,
  input  logic [W-1:0]  high_i,
  input  logic [DW-1:0] dead_i,
  output logic          p_o,
  output logic          n_o,
  output logic          start_o
);

  pwm_cfg_t     cfg_in, cfg_cur;
  logic         run;
  logic [W-1:0] cnt;
  logic         p_raw, n_raw, start_raw;

  assign cfg_in.period = CNT_W'(period_i);
  assign cfg_in.high   = CNT_W'(high_i);
  assign cfg_in.dead   = DT_W'(dead_i);

  pwm_pair_timer #(.W(W)) u_timer (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .en_i   (en_i),
    .cfg_i  (cfg_in),
    .run_o  (run),
    .cnt_o  (cnt),
    .cfg_o  (cfg_cur)
  );

  pwm_pair_window #(.W(W), .DW(DW), .DEAD_EN(DEAD_EN)) u_window (
    .cnt_i    (cnt),
    .period_i (W'(cfg_cur.period)),
    .high_i   (W'(cfg_cur.high)),
    .dead_i   (DW'(cfg_cur.dead)),
    .p_raw_o  (p_raw),
    .n_raw_o  (n_raw)
  );

  assign start_raw = (cnt == '0);

  pwm_pair_outreg u_out (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .en_i        (en_i),
    .run_i       (run),
    .p_raw_i     (p_raw),
    .n_raw_i     (n_raw),
    .start_raw_i (start_raw),
    .p_o         (p_o),
    .n_o         (n_o),
    .start_o     (start_o)
  );

  p_complement_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($past(en_i) && $past(run) && $past(cfg_cur.dead) == '0) |-> (p_o != n_o));

endmodule

// File: tb/pwm_pair_tb.sv
module pwm_pair_top_tb_top;

  localparam int unsigned W  = 16;
  localparam int unsigned DW = 8;

  logic          clk_i = 1'b0;
  logic          rst_ni = 1'b0;
  logic          en_i = 1'b0;
  logic [W-1:0]  period_i = 16'd4;
  logic [W-1:0]  high_i = 16'd2;
  logic [DW-1:0] dead_i = 8'd0;
  logic          p_o, n_o, start_o;

  int total = 0;
  int bad   = 0;

  // model state
  int mk, mper, mhi, mdt;
  string tag;

  always #4 clk_i = ~clk_i;

  pwm_pair_top #(.W(W), .DW(DW), .DEAD_EN(1'b1)) dut_i (
    .clk_i, .rst_ni, .en_i, .period_i, .high_i, .dead_i, .p_o, .n_o, .start_o
  );

  task automatic chk(input string req, input logic act, input logic exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s t=%0t k=%0d per=%0d hi=%0d dt=%0d actual=%b expected=%b",
               req, $time, mk, mper, mhi, mdt, act, exp);
    end
  endtask

  function automatic logic exp_p(int k, int per, int hi, int dt);
    if (hi == 0) return 1'b0;
    if (hi >= per) return 1'b1;
    return (k >= dt) && (k < hi);
  endfunction

  function automatic logic exp_n(int k, int per, int hi, int dt);
    if (hi == 0) return 1'b1;
    if (hi >= per) return 1'b0;
    return (k >= hi + dt) && (k < per);
  endfunction

  function automatic string tag_for(int per, int hi, int dt);
    if (hi == 0 || hi >= per) return "R3";
    if (dt == 0) return "R2";
    if (dt >= hi || hi + dt >= per) return "R9";
    return "R5";
  endfunction

  task automatic load_model();
    mk = 0; mper = int'(period_i); mhi = int'(high_i); mdt = int'(dead_i);
    tag = tag_for(mper, mhi, mdt);
  endtask

  task automatic start_run();
    @(negedge clk_i) en_i = 1'b1;
    @(negedge clk_i);  // capture edge has passed
    load_model();
  endtask

  task automatic run_cycles(int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk_i);
      chk(tag, p_o, exp_p(mk, mper, mhi, mdt));
      chk(tag, n_o, exp_n(mk, mper, mhi, mdt));
      chk("R1", start_o, (mk == 0));
      chk("R6", p_o && n_o, 1'b0);
      if (mdt == 0) chk("R4", n_o, ~p_o);
      if (mk + 1 >= mper) load_model();  // R8: capture at wrap
      else mk++;
    end
  endtask

  task automatic stop_run();
    @(negedge clk_i) en_i = 1'b0;
    @(negedge clk_i);
    chk("R7", p_o, 1'b0);
    chk("R7", n_o, 1'b0);
    chk("R7", start_o, 1'b0);
  endtask

  initial begin
    #(100000 * 8);
    bad++;
    $display("FAIL watchdog actual=hung expected=finished");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    // R7: outputs low during reset and while disabled
    repeat (3) @(negedge clk_i);
    chk("R7", p_o, 1'b0);
    chk("R7", n_o, 1'b0);
    chk("R7", start_o, 1'b0);
    rst_ni = 1'b1;
    repeat (2) @(negedge clk_i);
    chk("R7", p_o | n_o | start_o, 1'b0);

    // sweep small configurations; each run stops mid-period (R7 restart)
    for (int per = 1; per <= 6; per++) begin
      for (int hi = 0; hi <= 7; hi++) begin
        for (int dt = 0; dt <= 3; dt++) begin
          period_i = W'(per); high_i = W'(hi); dead_i = DW'(dt);
          start_run();
          run_cycles(2 * per + 1);
          stop_run();
        end
      end
    end

    // R8: mid-period change takes effect only after the wrap
    period_i = 16'd5; high_i = 16'd3; dead_i = 8'd1;
    start_run();
    run_cycles(2);
    period_i = 16'd4; high_i = 16'd2; dead_i = 8'd0;
    run_cycles(12);
    period_i = 16'd6; high_i = 16'd2; dead_i = 8'd1;
    run_cycles(13);
    stop_run();

    // R2/R4: default 2000-cycle frame, 1700 high
    period_i = 16'd2000; high_i = 16'd1700; dead_i = 8'd0;
    start_run();
    run_cycles(4001);
    stop_run();

    // R5: same frame with a 50-cycle dead band
    dead_i = 8'd50;
    start_run();
    run_cycles(4001);
    stop_run();

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule